// File: doc/BRIEF.md
# Half-Rate Capture to Full-Rate Serial Elastic Buffer

This block sits between a source-synchronous serial lane and a locally timed serialiser. The lane delivers one bit on each edge of a half-rate clock. The block receives those bits as a two-bit word on every rising edge of the write clock. Bit 0 of the word is the bit taken on the rising edge, and bit 1 is the bit taken on the following falling edge. The block places the bits in a small ring of bit cells. It reads them back one bit per cycle of a full-rate read clock, which is derived from an unrelated reference.

Write and read progress cross between the two domains as Gray-coded word pointers through multi-flop synchronisers. After reset the read side waits until half the ring is filled. From then on it emits one bit per read cycle. The fill level therefore starts in the middle of the ring, and slow phase drift between the two clocks can move it either way. A sticky error flag reports when the fill level comes within one cell of empty or of full.

Top module: `ddr_tx_fifo`

## Requirements
- R1: Within each two-bit write word, wdat_i[0] (the rising-edge bit) leaves sdat_o one read cycle before wdat_i[1] (the falling-edge bit).
- R2: With matched clock rates, every written bit appears on sdat_o exactly once, in write order and one bit per read cycle, whatever the fixed phase between the two clocks.
- R3: After reset, sdat_o stays 0 until the fill level seen in the read domain reaches DEPTH/2 bits. Once reading starts, it continues every cycle until the next reset.
- R4: A write clock whose period is off nominal, so that the phase error grows past 1.25 bit times over a run, causes no data error and does not raise err_o.
- R5: While reading, err_o rises when the fill level seen in the read domain is at most 1 bit (underflow) or at least DEPTH-1 bits (overflow). It never rises in normal operation.
- R6: Once set, err_o stays 1 until reset, even after the clocks return to matched rates.
- R7: While rst_ni is low (held for at least four read clocks), sdat_o and err_o are 0. After rst_ni is released, a new stream is delivered correctly from its first bit.
- R8: A bit captured at a write clock edge appears on sdat_o no more than DEPTH/2+8 read cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Half-rate write clock |
| rclk_i | input | 1 | Full-rate read clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wdat_i | input | 2 | Bit pair for this write cycle; bit 0 is emitted first |
| sdat_o | output | 1 | Serial output, one bit per read cycle |
| err_o | output | 1 | Sticky flag for underflow or overflow of the fill level |

## Verification
The bench builds the block with DEPTH=16 and SYNC_STAGES=2. This gives the ring enough headroom that the fill level stays centred under every fixed phase offset swept. A write period off by one part in 800 then accumulates about two bit times of drift without reaching either threshold. An offset of 20 parts in 800 drives the fill level into both the underflow limit and the overflow limit within a few hundred cycles. Fixed phase sweeps are run with three bit patterns. A marker bit placed at the start of each stream lets the bench align the output and measure latency arithmetically.

// File: rtl/ddr_fifo_pkg.sv
package ddr_fifo_pkg;
  localparam int unsigned WORD_BITS = 2;

  typedef enum logic {
    RD_FILL = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/ddr_gray_sync.sv
module ddr_gray_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ddr_fifo_wr.sv
module ddr_fifo_wr
  import ddr_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                                   wclk_i,
  input  logic                                   rst_ni,
  input  logic [WORD_BITS-1:0]                   wdat_i,
  output logic [$clog2(DEPTH/WORD_BITS):0]       wgray_o,
  output logic [DEPTH-1:0]                       mem_o
);
  localparam int unsigned NW = DEPTH / WORD_BITS;
  localparam int unsigned AW = $clog2(NW);

  logic [AW:0]          wbin;
  logic [AW:0]          wbin_nxt;
  logic [WORD_BITS-1:0] mem_q [NW];

  assign wbin_nxt = wbin + (AW+1)'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin    <= '0;
      wgray_o <= '0;
      for (int w = 0; w < int'(NW); w++) mem_q[w] <= '0;
    end else begin
      wbin    <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
      for (int w = 0; w < int'(NW); w++)
        if (wbin[AW-1:0] == AW'(w)) mem_q[w] <= wdat_i;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_out
    assign mem_o[w*WORD_BITS +: WORD_BITS] = mem_q[w];
  end

  // R2: pointer leaves the write domain one Gray bit at a time
  p_wgray_step_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1)
    else $error("write gray pointer changed more than one bit");
endmodule

// File: rtl/ddr_fifo_rd.sv
module ddr_fifo_rd
  import ddr_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                                   rclk_i,
  input  logic                                   rst_ni,
  input  logic [$clog2(DEPTH/WORD_BITS):0]       wgray_s_i,
  input  logic [DEPTH-1:0]                       mem_i,
  output logic                                   sdat_o,
  output logic                                   err_o
);
  localparam int unsigned AW = $clog2(DEPTH / WORD_BITS);
  localparam int unsigned PW = $clog2(DEPTH) + 1;
  localparam logic [PW-1:0] HALF_L = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LOW_L  = PW'(1);
  localparam logic [PW-1:0] HIGH_L = PW'(DEPTH - 1);

  logic [AW:0]    wbin_s;
  logic [PW-1:0]  wbits;
  logic [PW-1:0]  rptr;
  logic [PW-1:0]  occ;
  rd_state_e      st;
  logic           running;

  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign wbin_s[i] = ^wgray_s_i[AW:i];
  end

  assign wbits   = {wbin_s, 1'b0};
  assign occ     = wbits - rptr;
  assign running = (st == RD_RUN);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= RD_FILL;
      rptr   <= '0;
      sdat_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      case (st)
        RD_FILL: if (occ >= HALF_L) st <= RD_RUN;
        RD_RUN: begin
          rptr   <= rptr + PW'(1);
          sdat_o <= mem_i[rptr[PW-2:0]];
        end
        default: st <= RD_FILL;
      endcase
      if (running && (occ <= LOW_L || occ >= HIGH_L)) err_o <= 1'b1;
    end
  end

  p_err_sticky_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    err_o |=> err_o) else $error("error flag cleared without reset");

  p_fill_quiet_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !running |-> !sdat_o) else $error("output active before fill");

  p_run_entry_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(running) |-> $past(occ) >= HALF_L) else $error("read began below half fill");

  p_run_holds_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    running |=> running) else $error("reading stopped without reset");

  p_starve_flag_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (running && occ == '0) |=> err_o) else $error("empty ring not flagged");

  p_sync_step_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(wgray_s_i ^ $past(wgray_s_i)) <= 1)
    else $error("synchronised pointer jumped");
endmodule

// File: rtl/ddr_tx_fifo.sv
module ddr_tx_fifo
  import ddr_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic [1:0] wdat_i,
  output logic       sdat_o,
  output logic       err_o
);
  localparam int unsigned AW = $clog2(DEPTH / WORD_BITS);

  logic          w_rst_n;
  logic          r_rst_n;
  logic [AW:0]   wgray;
  logic [AW:0]   wgray_s;
  logic [DEPTH-1:0] mem;

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(w_rst_n)
  );

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(r_rst_n)
  );

  ddr_fifo_wr #(.DEPTH(DEPTH)) u_wr (
    .wclk_i (wclk_i),
    .rst_ni (w_rst_n),
    .wdat_i (wdat_i),
    .wgray_o(wgray),
    .mem_o  (mem)
  );

  ddr_gray_sync #(.WIDTH(AW+1), .STAGES(SYNC_STAGES)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(r_rst_n),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  ddr_fifo_rd #(.DEPTH(DEPTH)) u_rd (
    .rclk_i   (rclk_i),
    .rst_ni   (r_rst_n),
    .wgray_s_i(wgray_s),
    .mem_i    (mem),
    .sdat_o   (sdat_o),
    .err_o    (err_o)
  );

  // R7: outputs quiet while reset is applied
  p_reset_quiet_r7: assert property (@(posedge rclk_i)
    !rst_ni |-> (!sdat_o && !err_o)) else $error("outputs active in reset");
endmodule

// File: tb/sim_ddr_tx_fifo.sv
module sim_ddr_tx_fifo;
  localparam int RCLK_PERIOD = 800;
  localparam int DEPTH       = 16;
  localparam int HALF        = DEPTH / 2;
  localparam int WD_TIME     = 150000 * RCLK_PERIOD;

  logic       wclk = 1'b0;
  logic       rclk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] wdat_i = 2'b00;
  logic       sdat_o;
  logic       err_o;

  int     w_half = RCLK_PERIOD;
  int     w_skew = 0;
  int     checks = 0;
  int     errors = 0;
  bit     drv_on = 1'b0;
  int     wn = 0;
  int     mode = 0;
  longint t_mark = 0;

  ddr_tx_fifo #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wdat_i(wdat_i), .sdat_o(sdat_o), .err_o(err_o)
  );

  initial forever #(RCLK_PERIOD/2) rclk = ~rclk;

  initial forever begin
    #(w_half + w_skew);
    w_skew = 0;
    wclk = ~wclk;
  end

  function automatic logic sbit(input int p, input int k);
    int unsigned h;
    if (k == 0) return 1'b1;
    case (p)
      0: begin h = k * 32'd2654435761; return h[15]; end
      1: return k[0];
      default: return (k % 3) == 0;
    endcase
  endfunction

  // write driver: word n carries stream bits 2n (first) and 2n+1
  initial forever begin
    @(negedge wclk);
    if (drv_on) begin
      if (mode == 3) wdat_i = 2'b11;
      else wdat_i = {sbit(mode, 2*wn+1), sbit(mode, 2*wn)};
      if (wn == 0) t_mark = $time + w_half;
      wn++;
    end else begin
      wdat_i = 2'b00;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    drv_on = 1'b0;
    rst_ni = 1'b0;
    wn = 0;
    repeat (5) @(posedge rclk);
    @(negedge rclk);
    check(sdat_o == 1'b0, "R7 sdat in reset", sdat_o, 0);
    check(err_o == 1'b0, "R7 err in reset", err_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_stream(input int pat, input int skew, input int nbits,
                            input int wh, input string req);
    bit     found;
    longint lat;
    w_half = wh;
    w_skew = skew;
    do_reset();
    mode = pat;
    repeat (6) @(posedge wclk);
    drv_on = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 400 && !found; i++) begin
      @(negedge rclk);
      if (sdat_o) found = 1'b1;
    end
    check(found, {req, " marker seen"}, found, 1);
    if (found) begin
      lat = ($time - t_mark) / RCLK_PERIOD;
      check(lat <= HALF + 8, "R8 latency", lat, HALF + 8);
      for (int k = 1; k <= nbits; k++) begin
        @(negedge rclk);
        check(sdat_o == sbit(pat, k), {req, " stream bit"}, sdat_o, sbit(pat, k));
      end
    end
    check(err_o == 1'b0, "R5 no false flag", err_o, 0);
  endtask

  task automatic drift_to_error(input int wh);
    w_half = wh;
    repeat (1600) @(posedge rclk);
    @(negedge rclk);
    check(err_o == 1'b1, "R5 limit flagged", err_o, 1);
    w_half = RCLK_PERIOD;
    repeat (300) @(posedge rclk);
    @(negedge rclk);
    check(err_o == 1'b1, "R6 flag sticky", err_o, 1);
  endtask

  initial begin
    #(WD_TIME);
    errors++;
    $display("FAIL watchdog R2 actual 0 expected 1");
    summary();
  end

  initial begin
    int cnt;
    // R3: constant ones from reset; first 1 only after half fill, then no gaps
    w_half = RCLK_PERIOD;
    do_reset();
    mode = 3;
    drv_on = 1'b1;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge rclk);
      if (sdat_o) break;
      cnt++;
    end
    check(cnt >= HALF && cnt < 200, "R3 fill wait", cnt, HALF);
    for (int i = 0; i < 200; i++) begin
      @(negedge rclk);
      check(sdat_o == 1'b1, "R3 continuous read", sdat_o, 1);
    end

    // phase sweep over three patterns; pattern 1 alternates so order errors show
    for (int p = 0; p < 3; p++)
      for (int ph = 0; ph < 8; ph++)
        run_stream(p, ph * 100, 300, RCLK_PERIOD, (p == 1) ? "R1" : "R2");

    // R4: slow drift both ways
    run_stream(0, 0,   1500, RCLK_PERIOD + 1, "R4");
    run_stream(2, 300, 1500, RCLK_PERIOD - 1, "R4");

    // R5/R6: underflow then overflow
    run_stream(0, 0, 50, RCLK_PERIOD, "R2");
    drift_to_error(RCLK_PERIOD + 20);
    run_stream(1, 0, 50, RCLK_PERIOD, "R1");
    drift_to_error(RCLK_PERIOD - 20);

    // R7: reset clears the flag and a fresh stream is clean
    run_stream(2, 0, 300, RCLK_PERIOD, "R7");
    summary();
  end
endmodule